// File: doc/BRIEF.md
# ADC Window Test Sequencer

This block runs a fixed, eleven-step test that decides whether an analog input lies inside a tolerance window. It does this through the test controls of a successive-approximation converter: ADC enable, a 10-bit DAC code, the channel-select field, HOLD and an active-low precharge. Each step applies one row of controls. An external agent finishes one scan load and unload, then pulses `step_adv` to move the sequence to the next row.

The run samples the input twice, with HOLD low and the DAC parked at midpoint. After the first sample it compares the input against the lower limit code, and after the second against the upper limit code. The comparator result belongs to the row that was just applied, so it is captured on the `step_adv` strobe that ends each checking step. When the last step is done, `done` pulses for one cycle and one of `pass` or `fail` latches.

The limit codes are elaboration-time parameters. They follow limit = 1024 × nominal × (1 ∓ tolerance) / reference, which gives 291 and 323 for a 1.5 V ±5 % input on a 5.0 V reference.

Top module: `adcwin_seq`

## Requirements
- R1: While reset is high, and whenever no run is active, the outputs are adc_en=1, dac_code=0x200, mux_sel=0x08, hold=1, prech_n=1, and busy, done, pass and fail are all 0. Flags that were latched by an earlier run are the exception (see R9). Reset is synchronous and active-high, and a reset in the middle of a run aborts it.
- R2: A start pulse while idle raises busy on the next clock and applies step 1. Each step_adv pulse while busy advances the step by one on the following clock. Steps are numbered 1 to 11.
- R3: hold is 0 only at steps 2 and 7 and 1 at every other step. Whenever hold is 0, dac_code is 0x200.
- R4: dac_code is the lower limit (default 0x123 = 291) at steps 4 and 5. It is the upper limit (default 0x143 = 323) at steps 9 and 10. It is 0x200 at every other step.
- R5: prech_n is 0 only at steps 5 and 10 and 1 at every other step.
- R6: adc_en stays 1 and mux_sel stays 0x08 at every step and while idle.
- R7: comp_in is sampled on the step_adv that ends step 5, where it must be 0, and on the step_adv that ends step 10, where it must be 1. The value of comp_in at any other strobe has no effect on the verdict.
- R8: The step_adv that ends step 11 drops busy and raises done for exactly one cycle. On that same cycle exactly one of pass and fail becomes 1.
- R9: pass and fail hold their values until the next accepted start, which clears both.
- R10: A start pulse while busy is ignored, and the current step is kept.
- R11: A step_adv pulse while idle is ignored: busy stays 0 and the outputs keep their idle values.
- R12: A mismatch at either check sets fail=1 and pass=0 at the end of the run. No mismatch sets pass=1 and fail=0.
- R13: Elaboration stops with an error if the lower limit parameter is not below the upper limit parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| step_adv | input | 1 | One scan load/unload completed; end current step |
| comp_in | input | 1 | Comparator bit scanned out for the current step |
| adc_en | output | 1 | ADC enable control |
| dac_code | output | 10 | DAC code control |
| mux_sel | output | 8 | Channel-select mux field |
| hold | output | 1 | Sample/hold control, 0 = sample |
| prech_n | output | 1 | Active-low comparator precharge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at run completion |
| pass | output | 1 | Latched verdict: inside window |
| fail | output | 1 | Latched verdict: outside window |

## Verification
The bench forces a mismatch at each check separately. A design that captures the comparator on the strobe one step early or late, or that checks the wrong polarity, reports pass for a bad input or fail for a good one. It drives comp_in high at every non-checking strobe. This exposes a verdict that is polluted by samples that should be ignored. It also pulses start in the middle of a run, sends strobes while idle, and applies reset mid-run. A design that restarts, advances or keeps running in those cases shows the wrong row, a spurious busy, or stale flags.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;

    localparam int DAC_W   = 10;
    localparam int MUX_W   = 8;
    localparam int STEP_W  = 4;
    localparam int N_STEPS = 11;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [DAC_W-1:0]  dac_t;
    typedef logic [MUX_W-1:0]  mux_t;

    localparam dac_t DAC_MID = dac_t'(1 << (DAC_W - 1));

    // Step positions that carry behaviour
    localparam step_t S_FIRST   = step_t'(1);
    localparam step_t S_SAMP_LO = step_t'(2);
    localparam step_t S_LIM_LO  = step_t'(4);
    localparam step_t S_CHK_LO  = step_t'(5);
    localparam step_t S_SAMP_HI = step_t'(7);
    localparam step_t S_LIM_HI  = step_t'(9);
    localparam step_t S_CHK_HI  = step_t'(10);
    localparam step_t S_LAST    = step_t'(N_STEPS);

    typedef enum logic {PH_IDLE, PH_RUN} phase_e;

    typedef struct packed {
        logic en;
        dac_t dac;
        mux_t mux;
        logic hold;
        logic prech_n;
    } adc_ctrl_t;

    function automatic adc_ctrl_t rest_ctrl(mux_t m);
        adc_ctrl_t c;
        c.en      = 1'b1;
        c.dac     = DAC_MID;
        c.mux     = m;
        c.hold    = 1'b1;
        c.prech_n = 1'b1;
        return c;
    endfunction

    function automatic dac_t step_dac(step_t s, dac_t lo, dac_t hi);
        if (s == S_LIM_LO || s == S_CHK_LO)
            return lo;
        else if (s == S_LIM_HI || s == S_CHK_HI)
            return hi;
        return DAC_MID;
    endfunction

    function automatic adc_ctrl_t row_ctrl(step_t s, dac_t lo, dac_t hi, mux_t m);
        adc_ctrl_t c;
        c         = rest_ctrl(m);
        c.dac     = step_dac(s, lo, hi);
        c.hold    = !(s == S_SAMP_LO || s == S_SAMP_HI);
        c.prech_n = !(s == S_CHK_LO || s == S_CHK_HI);
        return c;
    endfunction

endpackage

// File: rtl/adcwin_stepper.sv
module adcwin_stepper
    import adcwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  step_adv,
    output step_t step,
    output logic  busy,
    output logic  accept,
    output logic  fire,
    output logic  finish,
    output logic  done
);
    phase_e phase;

    assign busy   = (phase == PH_RUN);
    assign accept = start && !busy;
    assign fire   = step_adv && busy;
    assign finish = fire && (step == S_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                phase <= PH_RUN;
                step  <= S_FIRST;
            end else if (finish) begin
                phase <= PH_IDLE;
                step  <= '0;
            end else if (fire) begin
                step <= step + step_t'(1);
            end
        end
    end
endmodule

// File: rtl/adcwin_rowgen.sv
module adcwin_rowgen
    import adcwin_pkg::*;
#(
    parameter int LO_CODE  = 291,
    parameter int HI_CODE  = 323,
    parameter int MUX_CODE = 8
) (
    input  step_t     step,
    input  logic      busy,
    output adc_ctrl_t ctrl
);
    localparam dac_t LO_D = dac_t'(LO_CODE);
    localparam dac_t HI_D = dac_t'(HI_CODE);
    localparam mux_t MX   = mux_t'(MUX_CODE);

    always_comb begin
        if (busy)
            ctrl = row_ctrl(step, LO_D, HI_D, MX);
        else
            ctrl = rest_ctrl(MX);
    end
endmodule

// File: rtl/adcwin_judge.sv
module adcwin_judge
    import adcwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  fire,
    input  logic  finish,
    input  step_t step,
    input  logic  comp_in,
    output logic  pass,
    output logic  fail
);
    logic err_q;
    logic mism;

    always_comb begin
        mism = 1'b0;
        if (fire && step == S_CHK_LO)
            mism = (comp_in != 1'b0);
        else if (fire && step == S_CHK_HI)
            mism = (comp_in != 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            err_q <= err_q | mism;
            if (finish) begin
                pass <= !(err_q | mism);
                fail <= err_q | mism;
            end
        end
    end
endmodule

// File: rtl/adcwin_seq.sv
module adcwin_seq
    import adcwin_pkg::*;
#(
    parameter int LO_CODE  = 291,
    parameter int HI_CODE  = 323,
    parameter int MUX_CODE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step_adv,
    input  logic             comp_in,
    output logic             adc_en,
    output logic [DAC_W-1:0] dac_code,
    output logic [MUX_W-1:0] mux_sel,
    output logic             hold,
    output logic             prech_n,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    // R13: window ordering checked at elaboration
    if (LO_CODE >= HI_CODE) begin : g_bad_window
        $error("lower limit code must be below upper limit code");
    end

    step_t     step;
    logic      accept, fire, finish;
    adc_ctrl_t ctrl;

    adcwin_stepper u_step (
        .clk(clk), .rst(rst), .start(start), .step_adv(step_adv),
        .step(step), .busy(busy), .accept(accept), .fire(fire),
        .finish(finish), .done(done)
    );

    adcwin_rowgen #(
        .LO_CODE(LO_CODE), .HI_CODE(HI_CODE), .MUX_CODE(MUX_CODE)
    ) u_row (
        .step(step), .busy(busy), .ctrl(ctrl)
    );

    adcwin_judge u_judge (
        .clk(clk), .rst(rst), .accept(accept), .fire(fire),
        .finish(finish), .step(step), .comp_in(comp_in),
        .pass(pass), .fail(fail)
    );

    assign adc_en   = ctrl.en;
    assign dac_code = ctrl.dac;
    assign mux_sel  = ctrl.mux;
    assign hold     = ctrl.hold;
    assign prech_n  = ctrl.prech_n;
endmodule

// File: rtl/adcwin_chk.sv
module adcwin_chk
    import adcwin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             step_adv,
    input logic             adc_en,
    input logic [DAC_W-1:0] dac_code,
    input logic [MUX_W-1:0] mux_sel,
    input logic             hold,
    input logic             prech_n,
    input logic             busy,
    input logic             done,
    input logic             pass,
    input logic             fail
);
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_sample_at_mid_R3: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (dac_code == DAC_MID));

    assert_precharge_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        !prech_n |-> (dac_code != DAC_MID && hold));

    assert_enable_and_mux_R6: assert property (@(posedge clk) disable iff (rst)
        adc_en && $stable(mux_sel));

    assert_done_verdict_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && (pass ^ fail)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_flags_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(pass) && $stable(fail)));

    assert_run_persists_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_adv) |=> busy);

    assert_idle_persists_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
endmodule

bind adcwin_seq adcwin_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .step_adv(step_adv),
    .adc_en(adc_en), .dac_code(dac_code), .mux_sel(mux_sel),
    .hold(hold), .prech_n(prech_n), .busy(busy), .done(done),
    .pass(pass), .fail(fail)
);

// File: tb/sim_adcwin_seq.sv
module sim_adcwin_seq;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       step_adv = 1'b0;
    logic       comp_in = 1'b0;
    logic       adc_en, hold, prech_n, busy, done, pass, fail;
    logic [9:0] dac_code;
    logic [7:0] mux_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    adcwin_seq u0 (
        .clk(clk), .rst(rst), .start(start), .step_adv(step_adv),
        .comp_in(comp_in), .adc_en(adc_en), .dac_code(dac_code),
        .mux_sel(mux_sel), .hold(hold), .prech_n(prech_n), .busy(busy),
        .done(done), .pass(pass), .fail(fail)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int e_dac(int k);
        if (k == 4 || k == 5) return 291;
        if (k == 9 || k == 10) return 323;
        return 512;
    endfunction

    // k = 0 means idle / rest vector
    task automatic check_row(int k);
        chk("R4 dac", dac_code, (k == 0) ? 512 : e_dac(k));
        chk("R3 hold", hold, (k == 2 || k == 7) ? 0 : 1);
        chk("R5 prech_n", prech_n, (k == 5 || k == 10) ? 0 : 1);
        chk("R6 adc_en", adc_en, 1);
        chk("R6 mux", mux_sel, 8);
        chk("R2 busy", busy, (k == 0) ? 0 : 1);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic strobe(logic c);
        @(negedge clk); step_adv = 1'b1; comp_in = c;
        @(negedge clk); step_adv = 1'b0; comp_in = 1'b0;
    endtask

    task automatic run_seq(logic lo_c, logic hi_c, logic noise, int gap);
        logic ok;
        ok = (lo_c == 1'b0) && (hi_c == 1'b1);
        pulse_start();
        chk("R9 pass cleared", pass, 0);
        chk("R9 fail cleared", fail, 0);
        check_row(1);
        for (int k = 1; k <= 11; k++) begin
            logic c;
            c = (k == 5) ? lo_c : (k == 10) ? hi_c : noise;
            repeat (gap) @(negedge clk);
            if (gap > 0) check_row(k);
            strobe(c);
            if (k < 11) begin
                check_row(k + 1);
                chk("R8 no early done", done, 0);
            end else begin
                chk("R8 done pulse", done, 1);
                chk("R8 busy drop", busy, 0);
                chk("R12 pass", pass, ok ? 1 : 0);
                chk("R12 fail", fail, ok ? 0 : 1);
                check_row(0);
            end
        end
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        chk("R9 pass held", pass, ok ? 1 : 0);
        chk("R9 fail held", fail, ok ? 0 : 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_row(0);
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 0);
        chk("R1 fail", fail, 0);
        rst = 1'b0;
        @(negedge clk);
        check_row(0);
    endtask

    task automatic t_pass();      run_seq(1'b0, 1'b1, 1'b0, 0); endtask // R7 R12
    task automatic t_noise();     run_seq(1'b0, 1'b1, 1'b1, 1); endtask // R7 other strobes ignored
    task automatic t_fail_lo();   run_seq(1'b1, 1'b1, 1'b0, 0); endtask // R12 lower mismatch
    task automatic t_fail_hi();   run_seq(1'b0, 1'b0, 1'b1, 0); endtask // R12 upper mismatch

    task automatic t_flags_hold();
        run_seq(1'b1, 1'b0, 1'b0, 0);
        repeat (6) @(negedge clk);
        chk("R9 fail still latched", fail, 1);
        chk("R9 pass still clear", pass, 0);
        pulse_start();
        chk("R9 start clears fail", fail, 0);
        chk("R2 busy after start", busy, 1);
        for (int k = 1; k <= 11; k++) strobe((k == 10) ? 1'b1 : 1'b0);
        chk("R12 pass after clean run", pass, 1);
    endtask

    task automatic t_start_busy();
        pulse_start();
        for (int k = 1; k <= 3; k++) strobe(1'b0);
        check_row(4);
        pulse_start();
        check_row(4);                 // R10 step kept
        chk("R10 pass not cleared", pass, 0);
        for (int k = 4; k <= 11; k++) strobe((k == 10) ? 1'b1 : 1'b0);
        chk("R10 run finished normally", done, 1);
        chk("R10 verdict pass", pass, 1);
        @(negedge clk);
    endtask

    task automatic t_idle_strobe();
        strobe(1'b1);
        chk("R11 busy stays low", busy, 0);
        chk("R11 no done", done, 0);
        chk("R11 pass kept", pass, 1);
        check_row(0);
        @(negedge clk);
        chk("R11 still idle", busy, 0);
    endtask

    task automatic t_reset_mid();
        pulse_start();
        for (int k = 1; k <= 4; k++) strobe(1'b0);
        check_row(5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_row(0);
        chk("R1 reset clears pass", pass, 0);
        chk("R1 reset clears fail", fail, 0);
        chk("R1 no done", done, 0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_noise();
        t_fail_lo();
        t_fail_hi();
        t_flags_hold();
        t_start_busy();
        t_idle_strobe();
        t_reset_mid();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule